// File: doc/BRIEF.md
# Domain Ownership Lock Register

This block is a hardware mutex that guards one shared resource (a memory slot, an address region or a peripheral) among up to 16 bus domains. Each write reaching it carries the writer's domain number; the value written is a command. A domain acquires the lock by writing the acquire command and then reading back the owner field. If the owner field holds its own domain number, the domain has the lock.

The lock leaves reset switched off and must be switched on with the release command before it can be taken. The owner gives the lock back with the release command. A domain that does not own the lock can still free it by writing two agreed magic values in consecutive writes. A kill command turns the lock off for good, and only a reset clears that. A combinational permission output tells a downstream policy checker whether the lock blocks the domain shown on a query input.

Top module: `eal_lock_reg`

## Requirements
- R1: After reset, lock_state reads 00 (off), lock_owner reads 0 and access_ok reads 1 for every domain.
- R2: A release write (value CMD_REL, default 0x1) while the lock is off and has not been killed sets lock_state to 01 (free) on the next cycle. An acquire write while the lock is off has no effect.
- R3: An acquire write (value CMD_ACQ, default 0x2) while the lock is free sets lock_state to 10 (held) and lock_owner to the writer's domain on the next cycle.
- R4: An acquire write while the lock is held, from any domain, leaves lock_state and lock_owner unchanged.
- R5: A release write from the owning domain while the lock is held returns it to free, with lock_owner reading 0.
- R6: A release write from a domain other than the owner while the lock is held is ignored.
- R7: A write of MAGIC_A (default 0xC3A50F1E) followed by a write of MAGIC_B (default 0x3C5AF0E1) as the very next write frees a held lock, whatever domain writes. Idle cycles between the two writes are allowed.
- R8: The forced release is cancelled if any other write comes between the two magic values, or if the write after MAGIC_A is not MAGIC_B. A MAGIC_B write that does not directly follow MAGIC_A has no effect.
- R9: A kill write (value CMD_KILL, default 0x0) sets lock_state to 00 and lock_owner to 0. From then until reset, every write is ignored.
- R10: access_ok is 1 only when chk_dom equals lock_owner while the lock is held, and 1 for every chk_dom while the lock is off or free.
- R11: A write of any value that is not one of the five command values changes neither lock_state nor lock_owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_dom | input | DOM_W | Domain number of the writer |
| wr_data | input | DATA_W | Command value being written |
| chk_dom | input | DOM_W | Domain queried for permission |
| lock_state | output | 2 | 00 off, 01 free, 10 held |
| lock_owner | output | DOM_W | Owning domain while held, otherwise 0 |
| access_ok | output | 1 | Lock does not block chk_dom |

## Verification
A wrong owner or state register shows up on lock_state and lock_owner one cycle after the write that corrupts it. It also shows on access_ok as soon as chk_dom names a domain that is wrongly blocked or wrongly let through. The kill flag and the armed magic flag cannot be seen directly. A stale kill flag shows as a later release write that fails to free the lock. A wrong armed flag shows only on the next held lock, as a MAGIC_B write whose outcome is wrong, so the stimulus has to set up that exact ordering of writes to expose it.

// File: rtl/eal_pkg.sv
package eal_pkg;
   typedef enum logic [1:0] {
      EAL_OFF  = 2'b00,
      EAL_FREE = 2'b01,
      EAL_HELD = 2'b10
   } eal_state_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_ACQ,
      OP_REL,
      OP_KILL,
      OP_ARM,
      OP_FIRE
   } eal_op_e;
endpackage

// File: rtl/eal_cmd_decode.sv
module eal_cmd_decode
   import eal_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] CMD_KILL = 'h0,
   parameter logic [DATA_W-1:0] CMD_REL  = 'h1,
   parameter logic [DATA_W-1:0] CMD_ACQ  = 'h2,
   parameter logic [DATA_W-1:0] MAGIC_A  = 'hC3A50F1E,
   parameter logic [DATA_W-1:0] MAGIC_B  = 'h3C5AF0E1
) (
   input  logic [DATA_W-1:0] data,
   output eal_op_e           op
);
   always_comb begin
      if (data == CMD_ACQ)       op = OP_ACQ;
      else if (data == CMD_REL)  op = OP_REL;
      else if (data == CMD_KILL) op = OP_KILL;
      else if (data == MAGIC_A)  op = OP_ARM;
      else if (data == MAGIC_B)  op = OP_FIRE;
      else                       op = OP_NONE;
   end
endmodule

// File: rtl/eal_force_seq.sv
module eal_force_seq
   import eal_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  eal_op_e op,
   output logic    fire
);
   logic armed_q;

   // Every write re-evaluates the arm flag; idle cycles keep it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed_q <= 1'b0;
      else if (wr_en) armed_q <= (op == OP_ARM);
   end

   assign fire = wr_en && (op == OP_FIRE) && armed_q;
endmodule

// File: rtl/eal_core.sv
module eal_core
   import eal_pkg::*;
#(
   parameter int DOM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DOM_W-1:0] wr_dom,
   input  eal_op_e          op,
   input  logic             fire,
   output eal_state_e       state,
   output logic [DOM_W-1:0] owner
);
   logic killed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= EAL_OFF;
         owner    <= '0;
         killed_q <= 1'b0;
      end else if (wr_en && !killed_q) begin
         unique case (op)
            OP_REL: begin
               if (state != EAL_HELD) begin
                  state <= EAL_FREE;
               end else if (wr_dom == owner) begin
                  state <= EAL_FREE;
                  owner <= '0;
               end
            end
            OP_ACQ: begin
               if (state == EAL_FREE) begin
                  state <= EAL_HELD;
                  owner <= wr_dom;
               end
            end
            OP_KILL: begin
               state    <= EAL_OFF;
               owner    <= '0;
               killed_q <= 1'b1;
            end
            OP_FIRE: begin
               if (fire && state == EAL_HELD) begin
                  state <= EAL_FREE;
                  owner <= '0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eal_gate.sv
module eal_gate
   import eal_pkg::*;
#(
   parameter int DOM_W = 4
) (
   input  eal_state_e       state,
   input  logic [DOM_W-1:0] owner,
   input  logic [DOM_W-1:0] chk_dom,
   output logic             allow
);
   assign allow = (state != EAL_HELD) || (chk_dom == owner);
endmodule

// File: rtl/eal_lock_reg.sv
module eal_lock_reg
   import eal_pkg::*;
#(
   parameter int DOM_W  = 4,
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] CMD_KILL = 'h0,
   parameter logic [DATA_W-1:0] CMD_REL  = 'h1,
   parameter logic [DATA_W-1:0] CMD_ACQ  = 'h2,
   parameter logic [DATA_W-1:0] MAGIC_A  = 'hC3A50F1E,
   parameter logic [DATA_W-1:0] MAGIC_B  = 'h3C5AF0E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DOM_W-1:0]  wr_dom,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DOM_W-1:0]  chk_dom,
   output logic [1:0]        lock_state,
   output logic [DOM_W-1:0]  lock_owner,
   output logic              access_ok
);
   localparam int MAX_DOMS = 1 << DOM_W;

   generate
      if (DOM_W < 1 || MAX_DOMS > 16) begin : g_bad_dom
         $error("eal_lock_reg: DOM_W must give 2 to 16 domains");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("eal_lock_reg: DATA_W must be at least 8");
      end
      if (MAGIC_A == MAGIC_B || MAGIC_A == CMD_REL || MAGIC_A == CMD_ACQ ||
          MAGIC_A == CMD_KILL || MAGIC_B == CMD_REL || MAGIC_B == CMD_ACQ ||
          MAGIC_B == CMD_KILL || CMD_REL == CMD_ACQ || CMD_REL == CMD_KILL ||
          CMD_ACQ == CMD_KILL) begin : g_bad_codes
         $error("eal_lock_reg: command values must be distinct");
      end
   endgenerate

   eal_op_e    op;
   logic       fire;
   eal_state_e state;

   eal_cmd_decode #(
      .DATA_W(DATA_W), .CMD_KILL(CMD_KILL), .CMD_REL(CMD_REL),
      .CMD_ACQ(CMD_ACQ), .MAGIC_A(MAGIC_A), .MAGIC_B(MAGIC_B)
   ) u_dec (
      .data (wr_data),
      .op   (op)
   );

   eal_force_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .op    (op),
      .fire  (fire)
   );

   eal_core #(.DOM_W(DOM_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_dom (wr_dom),
      .op     (op),
      .fire   (fire),
      .state  (state),
      .owner  (lock_owner)
   );

   eal_gate #(.DOM_W(DOM_W)) u_gate (
      .state   (state),
      .owner   (lock_owner),
      .chk_dom (chk_dom),
      .allow   (access_ok)
   );

   assign lock_state = state;
endmodule

// File: rtl/eal_lock_chk.sv
module eal_lock_chk #(
   parameter int DOM_W  = 4,
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] CMD_KILL = 'h0,
   parameter logic [DATA_W-1:0] CMD_REL  = 'h1,
   parameter logic [DATA_W-1:0] CMD_ACQ  = 'h2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DOM_W-1:0]  wr_dom,
   input logic [DATA_W-1:0] wr_data,
   input logic [DOM_W-1:0]  chk_dom,
   input logic [1:0]        lock_state,
   input logic [DOM_W-1:0]  lock_owner,
   input logic              access_ok
);
   logic seen_kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_kill <= 1'b0;
      else if (wr_en && wr_data == CMD_KILL) seen_kill <= 1'b1;
   end

   // R2
   enable_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_REL && lock_state == 2'b00 && !seen_kill)
      |=> lock_state == 2'b01);

   // R3
   acquire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_ACQ && lock_state == 2'b01)
      |=> (lock_state == 2'b10 && lock_owner == $past(wr_dom)));

   // R4
   acquire_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_ACQ && lock_state == 2'b10)
      |=> (lock_state == 2'b10 && $stable(lock_owner)));

   // R6
   foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data == CMD_REL && lock_state == 2'b10 && wr_dom != lock_owner)
      |=> (lock_state == 2'b10 && $stable(lock_owner)));

   // R9
   kill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_kill |-> (lock_state == 2'b00 && lock_owner == '0));

   // R10
   gate_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_state == 2'b10 && chk_dom != lock_owner) |-> !access_ok);

   // R10
   gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_state != 2'b10) |-> access_ok);
endmodule

bind eal_lock_reg eal_lock_chk #(
   .DOM_W(DOM_W), .DATA_W(DATA_W), .CMD_KILL(CMD_KILL),
   .CMD_REL(CMD_REL), .CMD_ACQ(CMD_ACQ)
) u_chk (.*);

// File: tb/sim_eal_lock_reg.sv
`timescale 1ns/1ps
module sim_eal_lock_reg;
   localparam int DOM_W  = 4;
   localparam int DATA_W = 32;
   localparam logic [31:0] C_KILL = 32'h0;
   localparam logic [31:0] C_REL  = 32'h1;
   localparam logic [31:0] C_ACQ  = 32'h2;
   localparam logic [31:0] C_MA   = 32'hC3A50F1E;
   localparam logic [31:0] C_MB   = 32'h3C5AF0E1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DOM_W-1:0]  wr_dom = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DOM_W-1:0]  chk_dom = '0;
   logic [1:0]        lock_state;
   logic [DOM_W-1:0]  lock_owner;
   logic              access_ok;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   logic [1:0]       m_state;
   logic [DOM_W-1:0] m_owner;
   bit               m_killed;
   bit               m_armed;

   always #5 clk = ~clk;

   eal_lock_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dom(wr_dom),
      .wr_data(wr_data), .chk_dom(chk_dom), .lock_state(lock_state),
      .lock_owner(lock_owner), .access_ok(access_ok)
   );

   function automatic void model_write(logic [DOM_W-1:0] d, logic [31:0] v);
      bit was_armed;
      if (m_killed) return;
      was_armed = m_armed;
      m_armed   = (v == C_MA);
      if (v == C_REL) begin
         if (m_state != 2'b10) m_state = 2'b01;
         else if (d == m_owner) begin m_state = 2'b01; m_owner = '0; end
      end else if (v == C_ACQ) begin
         if (m_state == 2'b01) begin m_state = 2'b10; m_owner = d; end
      end else if (v == C_KILL) begin
         m_state = 2'b00; m_owner = '0; m_killed = 1'b1;
      end else if (v == C_MB) begin
         if (was_armed && m_state == 2'b10) begin m_state = 2'b01; m_owner = '0; end
      end
   endfunction

   function automatic logic exp_allow(logic [DOM_W-1:0] q);
      return (m_state != 2'b10) || (q == m_owner);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag, logic [DOM_W-1:0] q);
      chk_dom = q;
      #1;
      check(tag, "lock_state", lock_state, m_state);
      check(tag, "lock_owner", lock_owner, m_owner);
      check(tag, "access_ok", access_ok, exp_allow(q));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      m_state = 2'b00; m_owner = '0; m_killed = 1'b0; m_armed = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one write; returns at the negedge after the capturing edge
   task automatic wr(logic [DOM_W-1:0] d, logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_dom = d; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(d, v);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      r = $urandom(32'd4242);
      do_reset();
      // R1 reset values, several query domains
      check_all("R1", 4'd0);
      check_all("R1", 4'd9);
      check("R1", "state_off", lock_state, 2'b00);

      // R2 acquire while off ignored, release enables
      wr(4'd3, C_ACQ);  check_all("R2", 4'd5);
      check("R2", "acq_while_off", lock_state, 2'b00);
      wr(4'd3, C_REL);  check_all("R2", 4'd5);
      check("R2", "enabled_free", lock_state, 2'b01);

      // R11 junk values ignored while free
      wr(4'd4, 32'h1234_5678); check_all("R11", 4'd4);

      // R3 acquire
      wr(4'd6, C_ACQ);  check_all("R3", 4'd6);
      check("R3", "owner", lock_owner, 6);
      check_all("R10", 4'd7);
      check("R10", "nonowner_blocked", access_ok, 0);

      // R4 acquire while held by another and by owner
      wr(4'd2, C_ACQ);  check_all("R4", 4'd2);
      wr(4'd6, C_ACQ);  check_all("R4", 4'd6);
      // R11 junk while held
      wr(4'd6, 32'hFFFF_FFFF); check_all("R11", 4'd6);

      // R6 foreign release ignored
      wr(4'd1, C_REL);  check_all("R6", 4'd1);
      check("R6", "still_held", lock_state, 2'b10);

      // R5 owner release
      wr(4'd6, C_REL);  check_all("R5", 4'd6);
      check("R5", "freed", lock_state, 2'b01);

      // R7 forced release with an idle gap
      wr(4'd15, C_ACQ);
      wr(4'd0, C_MA);
      repeat (3) @(negedge clk);
      wr(4'd0, C_MB);   check_all("R7", 4'd3);
      check("R7", "forced_free", lock_state, 2'b01);

      // R8 intervening write aborts
      wr(4'd8, C_ACQ);
      wr(4'd1, C_MA);
      wr(4'd1, 32'h55);
      wr(4'd1, C_MB);   check_all("R8", 4'd1);
      check("R8", "abort_between", lock_state, 2'b10);
      // R8 MAGIC_B without arming, then doubled MAGIC_A still works
      wr(4'd1, C_MB);   check_all("R8", 4'd8);
      wr(4'd1, C_MA); wr(4'd1, C_MA); wr(4'd1, C_MB);
      check_all("R7", 4'd1);
      check("R7", "rearm_free", lock_state, 2'b01);

      // R9 kill is sticky
      wr(4'd5, C_ACQ);
      wr(4'd2, C_KILL); check_all("R9", 4'd2);
      wr(4'd2, C_REL);  check_all("R9", 4'd2);
      check("R9", "no_reenable", lock_state, 2'b00);
      wr(4'd2, C_ACQ);  check_all("R9", 4'd2);
      do_reset();
      check_all("R1", 4'd3);
      wr(4'd2, C_REL);
      check("R9", "reset_clears_kill", lock_state, 2'b01);

      // constrained random segments
      for (int seg = 0; seg < 6; seg++) begin
         do_reset();
         wr(4'($urandom_range(0, 15)), C_REL);
         for (int n = 0; n < 400; n++) begin
            logic [31:0] v;
            int unsigned pick;
            logic [DOM_W-1:0] d;
            pick = $urandom_range(0, 99);
            d    = 4'($urandom_range(0, 15));
            if (pick < 30)      v = C_ACQ;
            else if (pick < 55) v = C_REL;
            else if (pick < 70) v = C_MA;
            else if (pick < 85) v = C_MB;
            else if (pick < 86) v = C_KILL;
            else                v = $urandom();
            if (v == C_REL && m_state == 2'b10 && pick < 45) d = m_owner;
            wr(d, v);
            check_all("R10", 4'($urandom_range(0, 15)));
            if (m_state == 2'b10) check_all("R10", m_owner);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule